// File: doc/BRIEF.md
# Zero-Hysteresis Bang-Bang Phase Current Regulator

This block chooses the switch state of every inverter phase leg from the sign of that phase's current error, where the error is the commanded current minus the sensed current. The block has no hysteresis band and does no pulse-width timing. When a phase needs more current, its high-side switch is commanded on. When a phase needs less current, its low-side switch is commanded on. When the error is exactly zero, the leg keeps the state it already had.

A decision is taken only at a permitted switching instant. The link sequencer marks such an instant with a one-cycle strobe, which it raises while the resonant link is shorted at zero voltage. Between strobes, the gate commands stay fixed even if the error changes sign. Every leg follows the same rule, and each leg is decided independently of the others.

Top module: `zhbb_regulator`

## Requirements
- R1: On reset, every high-side command (`gateHi`) is 0 and every low-side command (`gateLo`) is 1.
- R2: The error of phase k is `refCur[k]` minus `measCur[k]`. Both words are signed two's complement, `CUR_W` bits wide, and the subtraction is done at full precision with no wrap.
- R3: If `permit` is high on a clock edge and the error of phase k is greater than zero, then after that edge `gateHi[k]`=1 and `gateLo[k]`=0.
- R4: If `permit` is high on a clock edge and the error of phase k is less than zero, then after that edge `gateHi[k]`=0 and `gateLo[k]`=1.
- R5: If `permit` is high and the error of phase k is exactly zero, then both commands of leg k keep their previous values.
- R6: On an edge where `permit` is low, no gate command changes, whatever the current inputs are.
- R7: `gateHi[k]` and `gateLo[k]` are never both 1, and never both 0.
- R8: Each leg is decided only from its own phase's pair of current words. Phase k occupies bits [k*CUR_W +: CUR_W] of the packed inputs, and bit k of each gate output belongs to phase k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| permit | input | 1 | One-cycle strobe marking a zero-voltage switching instant |
| refCur | input | NPH*CUR_W | Packed signed reference currents, phase k in slice k |
| measCur | input | NPH*CUR_W | Packed signed measured currents, phase k in slice k |
| gateHi | output | NPH | High-side switch commands, bit k for phase k |
| gateLo | output | NPH | Low-side switch commands, bit k for phase k |

## Verification
The bench drives errors whose raw subtraction would overflow, for example the most positive reference minus the most negative measurement. A design that wrapped the subtraction would read the sign backwards and drive the wrong switch. It also applies exact-zero errors, which a design that treated zero as positive or negative would turn into a spurious leg flip. Opposite-sign errors are held on the inputs while the strobe is low, so a design that updated freely would change its gates between permitted instants. Every phase receives a different error sign, so swapped or shared phase slices would produce mismatched bits.

// File: rtl/zhbb_pkg.sv
package zhbb_pkg;
  typedef struct packed {
    logic capture;
  } ctrlStrobe_t;

  typedef enum logic [1:0] {
    SIGN_ZERO = 2'b00,
    SIGN_POS  = 2'b01,
    SIGN_NEG  = 2'b10
  } errSign_e;
endpackage

// File: rtl/zhbb_ctrl.sv
module zhbb_ctrl
  import zhbb_pkg::*;
(
  input  logic        permit,
  output ctrlStrobe_t strobes
);
  always_comb begin
    strobes.capture = permit;
  end
endmodule

// File: rtl/zhbb_leg.sv
module zhbb_leg
  import zhbb_pkg::*;
#(
  parameter int CUR_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             capture,
  input  logic [CUR_W-1:0] refWord,
  input  logic [CUR_W-1:0] measWord,
  output logic             hiCmd,
  output logic             loCmd
);
  localparam int ERR_W = CUR_W + 1;

  logic signed [ERR_W-1:0] errVal;
  errSign_e                errPol;
  logic                    hiState;

  always_comb begin
    errVal = $signed({refWord[CUR_W-1], refWord}) - $signed({measWord[CUR_W-1], measWord});
    if (errVal == '0)          errPol = SIGN_ZERO;
    else if (errVal[ERR_W-1])  errPol = SIGN_NEG;
    else                       errPol = SIGN_POS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiState <= 1'b0;
    end else if (capture) begin
      case (errPol)
        SIGN_POS: hiState <= 1'b1;
        SIGN_NEG: hiState <= 1'b0;
        default:  hiState <= hiState;
      endcase
    end
  end

  assign hiCmd = hiState;
  assign loCmd = ~hiState;
endmodule

// File: rtl/zhbb_datapath.sv
module zhbb_datapath
  import zhbb_pkg::*;
#(
  parameter int NPH   = 3,
  parameter int CUR_W = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobes,
  input  logic [NPH*CUR_W-1:0] refCur,
  input  logic [NPH*CUR_W-1:0] measCur,
  output logic [NPH-1:0]       gateHi,
  output logic [NPH-1:0]       gateLo
);
  for (genvar k = 0; k < NPH; k++) begin : g_leg
    zhbb_leg #(.CUR_W(CUR_W)) u_leg (
      .clk     (clk),
      .rstN    (rstN),
      .capture (strobes.capture),
      .refWord (refCur[k*CUR_W +: CUR_W]),
      .measWord(measCur[k*CUR_W +: CUR_W]),
      .hiCmd   (gateHi[k]),
      .loCmd   (gateLo[k])
    );
  end
endmodule

// File: rtl/zhbb_regulator.sv
module zhbb_regulator
  import zhbb_pkg::*;
#(
  parameter int NPH   = 3,
  parameter int CUR_W = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 permit,
  input  logic [NPH*CUR_W-1:0] refCur,
  input  logic [NPH*CUR_W-1:0] measCur,
  output logic [NPH-1:0]       gateHi,
  output logic [NPH-1:0]       gateLo
);
  ctrlStrobe_t strobes;

  zhbb_ctrl u_ctrl (
    .permit (permit),
    .strobes(strobes)
  );

  zhbb_datapath #(.NPH(NPH), .CUR_W(CUR_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .refCur (refCur),
    .measCur(measCur),
    .gateHi (gateHi),
    .gateLo (gateLo)
  );
endmodule

// File: rtl/zhbb_checker.sv
module zhbb_checker #(
  parameter int NPH   = 3,
  parameter int CUR_W = 12
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 permit,
  input logic [NPH*CUR_W-1:0] refCur,
  input logic [NPH*CUR_W-1:0] measCur,
  input logic [NPH-1:0]       gateHi,
  input logic [NPH-1:0]       gateLo
);
  logic [NPH-1:0] wantHi, wantLo;

  always_comb begin
    for (int k = 0; k < NPH; k++) begin
      wantHi[k] = $signed(refCur[k*CUR_W +: CUR_W]) > $signed(measCur[k*CUR_W +: CUR_W]);
      wantLo[k] = $signed(refCur[k*CUR_W +: CUR_W]) < $signed(measCur[k*CUR_W +: CUR_W]);
    end
  end

  // R7: the two commands of a leg are always complementary
  a_r7_complementary: assert property (@(posedge clk) disable iff (!rstN)
    (gateHi ^ gateLo) == {NPH{1'b1}});

  // R6: gates hold when no strobe
  a_r6_hold_without_permit: assert property (@(posedge clk) disable iff (!rstN)
    !permit |=> $stable(gateHi));

  // R3: a positive error drives the high side on
  a_r3_positive_high: assert property (@(posedge clk) disable iff (!rstN)
    permit |=> ((gateHi & $past(wantHi)) == $past(wantHi)));

  // R4: a negative error drives the low side on
  a_r4_negative_low: assert property (@(posedge clk) disable iff (!rstN)
    permit |=> ((gateLo & $past(wantLo)) == $past(wantLo)));

  // R5: a zero error leaves the leg unchanged
  a_r5_zero_holds: assert property (@(posedge clk) disable iff (!rstN)
    permit |=> (((gateHi ^ $past(gateHi)) & ~($past(wantHi) | $past(wantLo))) == '0));
endmodule

bind zhbb_regulator zhbb_checker #(.NPH(NPH), .CUR_W(CUR_W)) u_chk (
  .clk(clk), .rstN(rstN), .permit(permit),
  .refCur(refCur), .measCur(measCur),
  .gateHi(gateHi), .gateLo(gateLo)
);

// File: tb/zhbb_regulator_tb.sv
module zhbb_regulator_tb;
  localparam int NPH   = 3;
  localparam int CUR_W = 12;

  typedef struct {
    logic [NPH-1:0] hi;
    string          tag;
  } expItem_t;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 permit = 1'b0;
  logic [NPH*CUR_W-1:0] refCur = '0;
  logic [NPH*CUR_W-1:0] measCur = '0;
  logic [NPH-1:0]       gateHi, gateLo;

  int errors = 0;
  int checks = 0;
  logic [NPH-1:0] model = '0;
  expItem_t expQ[$];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  zhbb_regulator #(.NPH(NPH), .CUR_W(CUR_W)) u_dut (
    .clk(clk), .rstN(rstN), .permit(permit),
    .refCur(refCur), .measCur(measCur),
    .gateHi(gateHi), .gateLo(gateLo)
  );

  function automatic int sval(input logic [CUR_W-1:0] w);
    return int'($signed(w));
  endfunction

  // Drive one cycle and push the expected gate state after its edge
  task automatic apply(input bit p, input int r0, input int m0, input int r1,
                       input int m1, input int r2, input int m2, input string tag);
    int rs[NPH];
    int ms[NPH];
    rs[0] = r0; rs[1] = r1; rs[2] = r2;
    ms[0] = m0; ms[1] = m1; ms[2] = m2;
    @(negedge clk);
    permit = p;
    for (int k = 0; k < NPH; k++) begin
      refCur[k*CUR_W +: CUR_W]  = CUR_W'(rs[k]);
      measCur[k*CUR_W +: CUR_W] = CUR_W'(ms[k]);
      if (p) begin
        if (rs[k] > ms[k]) model[k] = 1'b1;
        else if (rs[k] < ms[k]) model[k] = 1'b0;
      end
    end
    expQ.push_back('{hi: model, tag: tag});
  endtask

  // Monitor: after each edge, compare at mid-cycle
  initial begin
    @(posedge rstN);
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        checks++;
        if (gateHi !== e.hi || gateLo !== ~e.hi) begin
          errors++;
          $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b", e.tag, gateHi, gateLo, e.hi, ~e.hi);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (gateHi !== 3'b000 || gateLo !== 3'b111) begin
      errors++;
      $display("FAIL R1 reset: hi=%b lo=%b expected hi=000 lo=111", gateHi, gateLo);
    end
    rstN = 1'b1;
    apply(1, 100, 50, -20, 30, 5, 5, "R3 R4 R5 R8 mixed");
    apply(0, -100, 50, 200, 30, 400, -5, "R6 hold flipped");
    apply(0, 0, 1000, 1000, 0, 0, 1000, "R6 hold again");
    apply(1, -100, 50, 200, 30, 400, -5, "R3 R4 R8 flip");
    apply(1, 7, 7, -3, -3, 0, 0, "R5 zero error holds");
    apply(1, 2047, -2048, -2048, 2047, 0, -1, "R2 overflow extremes");
    apply(1, -2048, 2047, 2047, -2048, -1, 0, "R2 overflow reversed");
    apply(1, 1, 0, 0, 1, 0, 0, "R3 R4 one LSB");
    apply(0, 500, -500, -500, 500, 500, -500, "R6 ignored");
    apply(1, 3, 3, 3, 3, 3, 3, "R5 all zero");
    apply(1, 10, -10, 10, -10, 10, -10, "R3 all positive");
    apply(1, -1, 1, -1, 1, -1, 1, "R4 all negative");
    apply(1, 10, -10, -1, 1, 10, -10, "R8 independent legs");
    for (int i = 0; i < 20; i++) begin
      int v;
      v = (i * 37) % 200 - 100;
      apply(bit'(i % 3 != 0), v, -v / 2, -v, v + 1, v / 3, 0, "R3 R4 R6 sweep");
    end
    @(negedge clk);
    permit = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: done=0 expected done=1");
      end
    join_any
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule